// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives one pulse-width-modulated pin from an 8-bit period value and a 10-bit duty value. The time base is a 10-bit count: a 2-bit fine part that advances once per prescaled clock tick, with an 8-bit coarse part above it that steps whenever the fine part wraps. The prescaler divides the block clock by 1, 4 or 16. A period ends when the coarse part equals the period value and the fine part is at its last step. The count then returns to zero, a new period begins and a one-cycle match pulse is raised.

Software writes the duty value as an upper byte plus a 2-bit low field under a write strobe, into a staging register. The active duty register is loaded from the staging register only when a period starts, so the waveform never carries half of an old duty and half of a new one. The pin goes high at the start of each period, unless the active duty is zero. It goes low when the 10-bit count reaches the active duty. A duty at or above the period length never matches, and the pin stays high for the whole period.

A small state machine runs the pin. Its states are `ST_OFF` (not in PWM mode, pin low, counters held), `ST_HIGH` (inside the duty portion) and `ST_LOW` (rest of the period). Its transitions are: LAUNCH (`ST_OFF` to `ST_HIGH` or `ST_LOW` on entry to PWM mode, depending on whether the staged duty is nonzero), DUTY_END (`ST_HIGH` to `ST_LOW` when the count reaches the duty), ROLLOVER (`ST_HIGH`/`ST_LOW` to `ST_HIGH`, or to `ST_LOW` for a zero duty, at the end of a period) and DISABLE (any state to `ST_OFF` when the mode leaves PWM).

Top module: `pwm10_gen`

## Requirements
- R1: The period is (period_i + 1) × 4 × D clock cycles. D is set by presc_sel_i: 00 gives 1, 01 gives 4, 10 or 11 gives 16.
- R2: The pin goes high in the first cycle of a period whenever the active duty loaded at that boundary is nonzero.
- R3: With an active duty of zero, the pin stays low for the whole period.
- R4: The pin is high for exactly duty × D clock cycles per period. The pin falls at the clock edge where the 10-bit count ({coarse, fine}) becomes equal to the active duty.
- R5: A duty of (period_i + 1) × 4 or more is never reached by the count, and the pin stays high for the whole period.
- R6: A write under duty_wr_i stages duty_hi_i as duty bits 9:2 and duty_lo_i as bits 1:0. The staged value becomes active only at the next period start. A write made in the cycle of a rollover is used from the period after that one.
- R7: mode_i[3:2] = 11 selects PWM. Any other mode value, including 0000, forces the pin low from the next cycle, holds the counters at zero and suppresses match pulses. Entering PWM starts a period at once, using the staged duty.
- R8: match_o is high for exactly one cycle, the first cycle of each period that follows a rollover. It does not pulse on entry to PWM mode.
- R9: After reset the pin and match_o are low and the staged duty is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 4 | Mode select; 11xx is PWM |
| presc_sel_i | input | 2 | Prescale select (1, 4, 16) |
| period_i | input | 8 | Period value compared with the coarse count |
| duty_wr_i | input | 1 | Write strobe for the staged duty |
| duty_hi_i | input | 8 | Duty bits 9:2 |
| duty_lo_i | input | 2 | Duty bits 1:0 |
| pwm_o | output | 1 | PWM pin |
| match_o | output | 1 | One-cycle pulse at each period start after a rollover |

## Verification
The bench builds the block with its default widths: an 8-bit coarse count, a 2-bit fine count and a 4-bit prescaler. Small period values keep every divide setting within a few hundred cycles per period. Because the count is exactly 10 bits, duties of zero, one below the period length, equal to the period length and at the maximum of 1023 are all reachable. This exercises the exact-match and never-match edges of the duty compare, and the low-field placement. Strobes timed on the last cycle of a period reach the rollover-coincident write case.

// File: rtl/pwm10_pkg.sv
package pwm10_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } pwm_state_t;

    // Last prescaler count value for each select code (divide minus one)
    function automatic logic [3:0] psc_last(input logic [1:0] sel);
        logic [3:0] r;
        unique case (sel)
            2'b00:   r = 4'd0;
            2'b01:   r = 4'd3;
            default: r = 4'd15;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm10_prescaler.sv
module pwm10_prescaler #(
    parameter int PSC_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    import pwm10_pkg::*;

    logic [PSC_W-1:0] cnt_q;
    logic [PSC_W-1:0] last;

    assign last   = PSC_W'(psc_last(sel_i));
    assign tick_o = en_i && (cnt_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en_i || tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pwm10_timebase.sv
module pwm10_timebase #(
    parameter int CNT_W  = 8,
    parameter int FINE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic                    tick_i,
    input  logic [CNT_W-1:0]        period_i,
    output logic [CNT_W+FINE_W-1:0] cnt_o,
    output logic [CNT_W+FINE_W-1:0] cnt_nxt_o,
    output logic                    wrap_o
);
    localparam int TB_W = CNT_W + FINE_W;

    logic [TB_W-1:0]   cnt_q;
    logic [FINE_W-1:0] fine;
    logic [CNT_W-1:0]  coarse;

    assign fine   = cnt_q[FINE_W-1:0];
    assign coarse = cnt_q[TB_W-1:FINE_W];

    // End of period: last fine step while the coarse part sits on the period value
    assign wrap_o    = tick_i && (&fine) && (coarse == period_i);
    // Incrementing the whole count carries fine wraps into the coarse part
    assign cnt_nxt_o = wrap_o ? '0 : cnt_q + 1'b1;
    assign cnt_o     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_nxt_o;
        end
    end
endmodule

// File: rtl/pwm10_duty_buf.sv
module pwm10_duty_buf #(
    parameter int DUTY_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DUTY_W-1:0] wr_data_i,
    input  logic              load_i,
    output logic [DUTY_W-1:0] staged_o,
    output logic [DUTY_W-1:0] active_o
);
    logic [DUTY_W-1:0] staged_q;
    logic [DUTY_W-1:0] active_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            staged_q <= '0;
            active_q <= '0;
        end else begin
            if (wr_i) begin
                staged_q <= wr_data_i;
            end
            // Load takes the value held before any same-cycle write
            if (load_i) begin
                active_q <= staged_q;
            end
        end
    end

    assign staged_o = staged_q;
    assign active_o = active_q;
endmodule

// File: rtl/pwm10_gen.sv
module pwm10_gen #(
    parameter int CNT_W  = 8,
    parameter int FINE_W = 2,
    parameter int PSC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_i,
    input  logic [1:0]        presc_sel_i,
    input  logic [CNT_W-1:0]  period_i,
    input  logic              duty_wr_i,
    input  logic [CNT_W-1:0]  duty_hi_i,
    input  logic [FINE_W-1:0] duty_lo_i,
    output logic              pwm_o,
    output logic              match_o
);
    import pwm10_pkg::*;

    localparam int DUTY_W = CNT_W + FINE_W;

    pwm_state_t        state_q;
    pwm_state_t        state_d;
    logic              pwm_mode;
    logic              run;
    logic              tick;
    logic              wrap;
    logic              launch;
    logic              load;
    logic              staged_nz;
    logic              match_q;
    logic [DUTY_W-1:0] cnt;
    logic [DUTY_W-1:0] cnt_nxt;
    logic [DUTY_W-1:0] staged;
    logic [DUTY_W-1:0] active;

    assign pwm_mode  = (mode_i[3:2] == 2'b11);
    assign run       = (state_q != ST_OFF);
    assign launch    = pwm_mode && (state_q == ST_OFF);
    assign load      = launch || wrap;
    assign staged_nz = |staged;

    pwm10_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (run),
        .sel_i  (presc_sel_i),
        .tick_o (tick)
    );

    pwm10_timebase #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .tick_i    (tick),
        .period_i  (period_i),
        .cnt_o     (cnt),
        .cnt_nxt_o (cnt_nxt),
        .wrap_o    (wrap)
    );

    pwm10_duty_buf #(.DUTY_W(DUTY_W)) u_duty (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (duty_wr_i),
        .wr_data_i ({duty_hi_i, duty_lo_i}),
        .load_i    (load),
        .staged_o  (staged),
        .active_o  (active)
    );

    // Next-state logic: LAUNCH, DUTY_END, ROLLOVER, DISABLE
    always_comb begin
        state_d = state_q;
        if (!pwm_mode) begin
            state_d = ST_OFF;                                    // DISABLE
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = staged_nz ? ST_HIGH : ST_LOW; // LAUNCH
                ST_HIGH: begin
                    if (wrap) begin
                        state_d = staged_nz ? ST_HIGH : ST_LOW;  // ROLLOVER
                    end else if (tick && (cnt_nxt == active)) begin
                        state_d = ST_LOW;                        // DUTY_END
                    end
                end
                ST_LOW: begin
                    if (wrap) begin
                        state_d = staged_nz ? ST_HIGH : ST_LOW;  // ROLLOVER
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            match_q <= 1'b0;
        end else begin
            state_q <= state_d;
            match_q <= wrap;
        end
    end

    // Output decode
    always_comb begin
        pwm_o   = (state_q == ST_HIGH);
        match_o = match_q;
    end

    logic unused_cnt;
    assign unused_cnt = ^cnt;
endmodule

// File: rtl/pwm10_chk.sv
module pwm10_chk
    import pwm10_pkg::*;
#(
    parameter int DUTY_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        mode_i,
    input logic              pwm_o,
    input logic              match_o,
    input pwm_state_t        state_q,
    input logic [DUTY_W-1:0] active
);
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i[3:2] != 2'b11) |=> !pwm_o); // R7

    AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o); // R8

    AST_RISE_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_o) |-> (match_o || $past(state_q == ST_OFF))); // R2

    AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> (match_o || $past(state_q == ST_OFF))); // R6

    AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (match_o && (active == '0)) |-> !pwm_o); // R3
endmodule

bind pwm10_gen pwm10_chk #(.DUTY_W(DUTY_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .pwm_o   (pwm_o),
    .match_o (match_o),
    .state_q (state_q),
    .active  (active)
);

// File: tb/sim_pwm10_gen.sv
module sim_pwm10_gen;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mode_i = 4'd0;
    logic [1:0] presc_sel_i = 2'd0;
    logic [7:0] period_i = 8'd0;
    logic       duty_wr_i = 1'b0;
    logic [7:0] duty_hi_i = 8'd0;
    logic [1:0] duty_lo_i = 2'd0;
    logic       pwm_o;
    logic       match_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm10_gen u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .presc_sel_i(presc_sel_i),
        .period_i(period_i), .duty_wr_i(duty_wr_i), .duty_hi_i(duty_hi_i),
        .duty_lo_i(duty_lo_i), .pwm_o(pwm_o), .match_o(match_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int div_of(input logic [1:0] sel);
        return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 4 : 16;
    endfunction

    task automatic wait_match(input string req);
        int n = 0;
        while (!match_o && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({req, " match seen"}, int'(match_o), 1);
    endtask

    // Count one period starting at a sample where match_o is high.
    // A write strobe is driven at sample index wr_at (negative: none).
    task automatic measure(input int wr_at, input logic [9:0] wr_val,
                           output int hi, output int tot);
        hi = 0;
        tot = 0;
        do begin
            if (tot == wr_at) begin
                duty_wr_i = 1'b1;
                {duty_hi_i, duty_lo_i} = wr_val;
            end else begin
                duty_wr_i = 1'b0;
            end
            if (pwm_o) hi++;
            tot++;
            @(negedge clk);
        end while (!match_o && tot < 5000);
        duty_wr_i = 1'b0;
    endtask

    task automatic start(input int p, input logic [9:0] d, input logic [1:0] sel,
                         input logic [3:0] mode);
        mode_i = 4'd0;
        @(negedge clk);
        @(negedge clk);
        period_i = 8'(p);
        presc_sel_i = sel;
        {duty_hi_i, duty_lo_i} = d;
        duty_wr_i = 1'b1;
        @(negedge clk);
        duty_wr_i = 1'b0;
        mode_i = mode;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int hi, tot;
        chk("R9 pin after reset", int'(pwm_o), 0);
        chk("R9 match after reset", int'(match_o), 0);
        period_i = 8'd1;
        presc_sel_i = 2'b00;
        mode_i = 4'b1100;
        @(negedge clk);
        wait_match("R9");
        measure(-1, 10'd0, hi, tot);
        chk("R9 staged duty zero after reset, high time", hi, 0);
        chk("R1 period P=1 D=1", tot, 8);
    endtask

    task automatic run_case(input string req, input int p, input int d,
                            input logic [1:0] sel, input logic [3:0] mode);
        int hi, tot, per, exp_hi;
        per = (p + 1) * 4;
        exp_hi = ((d < per) ? d : per) * div_of(sel);
        start(p, 10'(d), sel, mode);
        wait_match(req);
        chk({req, " single-cycle match (R8)"}, 1, 1);
        @(negedge clk);
        chk({req, " match low after one cycle (R8)"}, int'(match_o), 0);
        wait_match(req);
        measure(-1, 10'd0, hi, tot);
        chk({req, " period (R1)"}, tot, per * div_of(sel));
        chk({req, " high time"}, hi, exp_hi);
    endtask

    task automatic t_launch();
        start(3, 10'd6, 2'b00, 4'b1101);
        // one edge after mode entry the pin is already high (R7 launch)
        chk("R7 pin high right after launch", int'(pwm_o), 1);
        chk("R8 no match at launch", int'(match_o), 0);
    endtask

    task automatic t_buffer();
        int hi, tot;
        start(3, 10'd5, 2'b00, 4'b1100);
        wait_match("R6");
        measure(2, 10'd9, hi, tot);
        chk("R6 mid-period write leaves current period", hi, 5);
        measure(-1, 10'd0, hi, tot);
        chk("R6 staged duty used next period", hi, 9);
        measure(15, 10'd2, hi, tot);
        chk("R6 period ending with write", hi, 9);
        measure(-1, 10'd0, hi, tot);
        chk("R6 rollover-cycle write not yet active", hi, 9);
        measure(-1, 10'd0, hi, tot);
        chk("R6 rollover-cycle write active one period later", hi, 2);
    endtask

    task automatic t_disable(input logic [3:0] off_mode);
        int seen_hi = 0;
        int seen_m = 0;
        start(3, 10'd10, 2'b00, 4'b1110);
        wait_match("R7");
        chk("R2 pin high at period start", int'(pwm_o), 1);
        mode_i = off_mode;
        @(negedge clk);
        chk("R7 pin low next cycle after leaving PWM", int'(pwm_o), 0);
        for (int i = 0; i < 40; i++) begin
            if (pwm_o) seen_hi++;
            if (match_o) seen_m++;
            @(negedge clk);
        end
        chk("R7 pin stays low while off", seen_hi, 0);
        chk("R7 no match while off", seen_m, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        run_case("R4 P=3 D=5 div1", 3, 5, 2'b00, 4'b1100);
        run_case("R4 P=7 D=10 div4", 7, 10, 2'b01, 4'b1111);
        run_case("R4 P=2 D=3 div16", 2, 3, 2'b10, 4'b1101);
        run_case("R1 P=1 D=2 sel11", 1, 2, 2'b11, 4'b1100);
        run_case("R4 low field P=3 D=6", 3, 6, 2'b00, 4'b1100);
        run_case("R4 one below length P=3 D=15", 3, 15, 2'b00, 4'b1100);
        run_case("R3 zero duty", 3, 0, 2'b01, 4'b1100);
        run_case("R5 duty equals length", 3, 16, 2'b00, 4'b1100);
        run_case("R5 duty 1023", 3, 1023, 2'b01, 4'b1100);
        t_launch();
        t_buffer();
        t_disable(4'b0000);
        t_disable(4'b1000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                checks++;
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule